// File: doc/BRIEF.md
# Active-Clamp Gate Timing Generator

This block produces the gate drive for the auxiliary clamp switch of an isolated full-bridge converter. It works only from the main bridge gate pulses that it observes, and it uses registered edge detection to do so. The same two gate inputs carry the leading-leg pulses in buck (charging) operation and the two interleaved main-switch pulse trains in boost (discharging) operation. A mode select chooses which timing rule applies.

In buck operation, a falling edge on either observed pulse starts a clamp pulse. That pulse lasts a programmed number of clock cycles. The default of 40 cycles at a 50 MHz system clock gives about 0.8 µs inside a 50 µs switching period. In boost operation, a single rule applies: the clamp turns on at a pulse trailing edge and turns off at a pulse rising edge. This rule yields the correct clamp position whether duty is below or above one half, so start-up and regular boost operation need no separate handling.

Top module: `clamp_gate_gen`

## Requirements
- R1: While `rst_n` is low, `clamp_g` is low whatever the gate inputs do.
- R2: In buck mode (`mode_boost`=0), a falling edge on `gate_a` or `gate_b` sets `clamp_g` high at the first clock edge that samples the input low.
- R3: In buck mode, the clamp pulse stays high for exactly `pulse_len` clock cycles. A `pulse_len` of 0 produces no pulse.
- R4: `pulse_len` is sampled only when a pulse starts. A change during a pulse does not alter that pulse's length.
- R5: In buck mode, a falling edge that arrives during an active pulse restarts the count, so the pulse ends `pulse_len` cycles after the new edge.
- R6: In buck mode, rising edges on the gate inputs have no effect on `clamp_g`.
- R7: In boost mode (`mode_boost`=1), a falling edge on either gate input sets `clamp_g` at the sampling clock edge.
- R8: In boost mode, a rising edge on either gate input clears `clamp_g`. With no edge, `clamp_g` holds its value.
- R9: In boost mode, when a falling edge and a rising edge are sampled in the same cycle, `clamp_g` goes low.
- R10: On the clock edge where `mode_boost` differs from its previous value, `clamp_g` goes low. Edges on that cycle are ignored, and the edge history is reloaded from the present inputs.
- R11: In boost mode, two trains 180° apart give the set/reset waveform of R7 to R9 at every duty from 1/20 to 19/20 of the period, on both sides of 50%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_boost | input | 1 | 0 selects buck timing, 1 selects boost timing |
| gate_a | input | 1 | First observed main gate pulse (synchronous to clk) |
| gate_b | input | 1 | Second observed main gate pulse (synchronous to clk) |
| pulse_len | input | CNT_W | Buck clamp pulse length in clock cycles |
| clamp_g | output | 1 | Clamp switch gate |

## Verification
Every input change is applied 1 ns after a rising clock edge. Its effect on `clamp_g` is due at the very next rising edge, one register deep. The bench therefore compares the output 1 ns after each edge against an expected value that it advances one cycle at a time from the requirement rules. A buck pulse is due to stay high for `pulse_len` of these samples, starting with the sample right after the trailing edge. A restart or a mode change is due to take effect in the same single cycle.

// File: rtl/clamp_gate_gen.sv
module clamp_gate_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_boost,
  input  logic             gate_a,
  input  logic             gate_b,
  input  logic [CNT_W-1:0] pulse_len,
  output logic             clamp_g
);
  logic             a_q, b_q, mode_q;
  logic [CNT_W-1:0] cnt;

  wire mode_sw = mode_boost ^ mode_q;
  wire trail   = (a_q & ~gate_a) | (b_q & ~gate_b);
  wire lead    = (~a_q & gate_a) | (~b_q & gate_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      mode_q  <= 1'b0;
      cnt     <= '0;
      clamp_g <= 1'b0;
    end else begin
      a_q    <= gate_a;
      b_q    <= gate_b;
      mode_q <= mode_boost;
      if (mode_sw) begin
        clamp_g <= 1'b0;
        cnt     <= '0;
      end else if (mode_boost) begin
        cnt <= '0;
        if (lead)       clamp_g <= 1'b0;
        else if (trail) clamp_g <= 1'b1;
      end else if (trail) begin
        clamp_g <= (pulse_len != '0);
        cnt     <= pulse_len;
      end else if (clamp_g) begin
        if (cnt <= CNT_W'(1)) begin
          clamp_g <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

module clamp_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_boost,
  input logic             gate_a,
  input logic             gate_b,
  input logic [CNT_W-1:0] pulse_len,
  input logic             clamp_g
);
  logic pa, pb, pm, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= 1'b0; pb <= 1'b0; pm <= 1'b0; seen <= 1'b0;
    end else begin
      pa <= gate_a; pb <= gate_b; pm <= mode_boost; seen <= 1'b1;
    end
  end

  wire fall_o = (pa & ~gate_a) | (pb & ~gate_b);
  wire rise_o = (~pa & gate_a) | (~pb & gate_b);
  wire same_m = seen && (pm == mode_boost);

  // R2
  buck_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_m && !mode_boost && fall_o && pulse_len != '0) |=> clamp_g);
  // R6
  buck_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_m && !mode_boost && !fall_o && !clamp_g) |=> !clamp_g);
  // R7
  boost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_m && mode_boost && fall_o && !rise_o) |=> clamp_g);
  // R9
  boost_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_m && mode_boost && rise_o) |=> !clamp_g);
  // R8
  boost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (same_m && mode_boost && !rise_o && !fall_o) |=> $stable(clamp_g));
  // R10
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pm != mode_boost) |=> !clamp_g);
endmodule

bind clamp_gate_gen clamp_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_boost(mode_boost), .gate_a(gate_a),
  .gate_b(gate_b), .pulse_len(pulse_len), .clamp_g(clamp_g));

// File: tb/tb_clamp_gate_gen.sv
module tb_clamp_gate_gen;
  localparam int CNT_W = 8;
  localparam int PER   = 20;

  logic clk = 1'b0, rst_n = 1'b0, mode_boost = 1'b0, gate_a = 1'b0, gate_b = 1'b0;
  logic [CNT_W-1:0] pulse_len = 8'd40;
  logic clamp_g;
  int checks = 0, errors = 0;
  logic e_pa = 0, e_pb = 0, e_m = 0, e_c = 0;
  int e_cnt = 0;

  clamp_gate_gen #(.CNT_W(CNT_W)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string r, input logic exp);
    checks++;
    if (clamp_g !== exp) begin
      errors++;
      $display("FAIL %s: clamp_g=%b expected %b at %0t", r, clamp_g, exp, $time);
    end
  endtask

  task automatic tick(input string r);
    logic fl, rs;
    fl = (e_pa & ~gate_a) | (e_pb & ~gate_b);
    rs = (~e_pa & gate_a) | (~e_pb & gate_b);
    if (mode_boost != e_m) begin e_c = 0; e_cnt = 0; end
    else if (mode_boost) begin
      if (rs) e_c = 0; else if (fl) e_c = 1;
    end else if (fl) begin e_cnt = pulse_len; e_c = (pulse_len != 0); end
    else if (e_c) begin
      if (e_cnt <= 1) e_c = 0; else e_cnt--;
    end
    e_pa = gate_a; e_pb = gate_b; e_m = mode_boost;
    @(posedge clk); #1;
    check(r, e_c);
  endtask

  task automatic ticks(input string r, input int n);
    for (int i = 0; i < n; i++) tick(r);
  endtask

  initial begin
    #900us;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds clamp low while gates toggle in both modes
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      gate_a = i[0]; gate_b = ~i[0]; mode_boost = i[1];
      check("R1", 1'b0);
    end
    gate_a = 0; gate_b = 0; mode_boost = 0;
    @(posedge clk); #1;
    rst_n = 1;
    ticks("R1", 3);

    // R2/R3: buck width sweep on alternating inputs
    for (int w = 0; w <= 12; w++) begin
      pulse_len = w[CNT_W-1:0];
      if (w[0]) gate_a = 1; else gate_b = 1;
      ticks("R6", 4);
      gate_a = 0; gate_b = 0;
      tick("R2");
      ticks("R3", 15);
    end

    // R4: length change during a pulse is ignored
    pulse_len = 6; gate_a = 1; tick("R4");
    gate_a = 0; tick("R4");
    pulse_len = 2; ticks("R4", 10);

    // R5: retrigger during a pulse restarts the count
    pulse_len = 8; gate_a = 1; gate_b = 1; tick("R5");
    gate_a = 0; ticks("R5", 3);
    gate_b = 0; ticks("R5", 12);

    // R6: rising edge during a pulse does not cut it
    pulse_len = 10; gate_a = 1; tick("R6");
    gate_a = 0; ticks("R6", 3);
    gate_b = 1; ticks("R6", 10);
    gate_b = 0; ticks("R6", 12);

    // R10: buck pulse aborted by switch to boost, edge on that cycle ignored
    gate_a = 1; tick("R10");
    gate_a = 0; ticks("R10", 2);
    mode_boost = 1; gate_a = 1; tick("R10");
    gate_a = 0; tick("R7");
    tick("R8");

    // R7/R8/R9 directed in boost
    gate_a = 1; tick("R8");
    gate_b = 1; tick("R8");
    gate_a = 0; tick("R7");
    ticks("R8", 3);
    gate_a = 1; gate_b = 0; tick("R9");
    gate_a = 0; tick("R7");

    // R11: interleaved duty sweep, both sides of 50%
    gate_a = 0; gate_b = 0; ticks("R11", 2);
    for (int d = 1; d < PER; d++) begin
      for (int t = 0; t < 3 * PER; t++) begin
        gate_a = ((t % PER) < d);
        gate_b = (((t + PER / 2) % PER) < d);
        tick("R11");
      end
    end

    // R10: switch to buck with clamp high and a trailing edge on that cycle
    gate_a = 1; gate_b = 0; tick("R10");
    gate_a = 0; tick("R7");
    gate_b = 1; tick("R8");
    gate_b = 0; tick("R7");
    mode_boost = 0; gate_a = 1; tick("R10");
    gate_a = 0; pulse_len = 4; tick("R2");
    ticks("R3", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule